// File: doc/BRIEF.md
# LDPC Iteration Controller with Syndrome Check

This block sequences the iterative message-passing decoder of a small quasi-cyclic LDPC code and decides when decoding ends. After a start request it runs iterations. Each iteration is a bit-to-check phase followed by a check-to-bit phase, and each phase holds its enable strobe for a fixed number of cycles. The node arrays do the arithmetic. On the first bit-to-check phase a flag tells the bit nodes to seed their outgoing messages from the channel priors.

On the last cycle of every check-to-bit phase the block takes the hard-decision vector from the bit nodes. A bit node reports 1 when the sign of its total log-likelihood favours 1. The block evaluates every row of a fixed parity-check matrix on that vector, combinationally. Decoding ends at once when all checks are satisfied. Otherwise it ends when the number of completed iterations reaches a run-time cap.

When decoding ends, the block pulses `done_o` for one cycle. It then presents the decoded word, a converged flag and the number of iterations used, and holds all three until the next decode finishes.

The matrix is built from `NC` × `NB` circulant permutation blocks of size `Z`. Every check row therefore has weight `NB` and every bit column has weight `NC`.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `v2c_en_o`, `c2v_en_o`, `first_pass_o` and `converged_o` are 0, `word_o` and `iters_o` are 0, and the iteration cap holds 10.
- R2: A `start_i` seen while idle raises `v2c_en_o` on the next cycle for `PHASE_LEN` cycles. `c2v_en_o` then follows for `PHASE_LEN` cycles, and the two phases alternate for each later iteration. The two enables are never high together.
- R3: `first_pass_o` is high exactly during the bit-to-check phase of the first iteration of a decode.
- R4: Check row `g*Z+i` (with g < NC and i < Z) covers bit `k*Z + ((i + g*k) mod Z)` for every k < NB. A row is satisfied when the XOR of its covered hard decisions is 0.
- R5: If every row is satisfied by `hd_i` on the last cycle of a check-to-bit phase, decoding stops. On the next cycle `done_o` is 1, `converged_o` is 1, `word_o` equals the sampled `hd_i`, `iters_o` is the iteration count, `busy_o` is 0, and no further phase strobe follows.
- R6: If some row is unsatisfied when the completed iteration count reaches the cap, decoding stops with `converged_o` = 0 and `iters_o` = cap.
- R7: `done_o` is high for exactly one cycle per decode. `word_o`, `converged_o` and `iters_o` keep their values until the next decode ends.
- R8: `start_i` while busy is ignored. The running decode keeps its phase sequence and iteration count, and it produces a single `done_o`.
- R9: A cycle with `max_iter_wr_i` = 1 loads `max_iter_i` into the cap. A cap of 0 acts as a cap of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a decode (taken only when idle) |
| max_iter_wr_i | input | 1 | Load strobe for the iteration cap |
| max_iter_i | input | IW | New iteration cap value |
| hd_i | input | NB*Z | Hard decisions from the bit nodes |
| v2c_en_o | output | 1 | Bit-to-check phase enable |
| c2v_en_o | output | 1 | Check-to-bit phase enable |
| first_pass_o | output | 1 | Seed messages from channel priors |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| converged_o | output | 1 | Final syndrome was all zero |
| word_o | output | NB*Z | Decoded word |
| iters_o | output | IW | Iterations used by the last decode |

## Verification
The hardest situation to reach from the ports is convergence on a chosen later iteration, preceded by iterations whose words fail at least one check. The hard decisions only matter on one cycle of each iteration. The bench therefore keeps a per-iteration list of words and indexes it with its own model's iteration count, so the change to a codeword lands exactly on the intended check-to-bit phase. Cap exhaustion, a zero cap and start pulses in the middle of a decode are reached by loading the cap between decodes and pulsing `start_i` on chosen cycles inside a busy decode.

// File: rtl/ldpc_ctl_pkg.sv
package ldpc_ctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_V2C  = 2'd1,
      ST_C2V  = 2'd2
   } ctl_state_t;

   // Column touched by check row (grp, row) inside bit block blk.
   function automatic int unsigned h_bit_col(input int unsigned grp,
                                             input int unsigned row,
                                             input int unsigned blk,
                                             input int unsigned z);
      return blk * z + ((row + grp * blk) % z);
   endfunction

endpackage

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome #(
   parameter int unsigned Z  = 5,
   parameter int unsigned NB = 4,
   parameter int unsigned NC = 3
) (
   input  logic [NB*Z-1:0] hd_i,
   output logic            zero_o
);
   import ldpc_ctl_pkg::*;

   localparam int unsigned M = NC * Z;

   logic [M-1:0] syn;

   for (genvar g = 0; g < NC; g++) begin : g_grp
      for (genvar i = 0; i < Z; i++) begin : g_row
         logic [NB-1:0] taps;
         for (genvar k = 0; k < NB; k++) begin : g_tap
            assign taps[k] = hd_i[h_bit_col(g, i, k, Z)];
         end
         assign syn[g*Z+i] = ^taps;
      end
   end

   assign zero_o = ~|syn;

endmodule

// File: rtl/ldpc_iter_cap.sv
module ldpc_iter_cap #(
   parameter int unsigned IW        = 8,
   parameter int unsigned RESET_CAP = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [IW-1:0] val_i,
   output logic [IW-1:0] cap_eff_o
);
   logic [IW-1:0] cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cap_q <= IW'(RESET_CAP);
      else if (wr_i) cap_q <= val_i;
   end

   assign cap_eff_o = (cap_q == '0) ? IW'(1) : cap_q;

endmodule

// File: rtl/ldpc_phase_seq.sv
module ldpc_phase_seq #(
   parameter int unsigned PHASE_LEN = 2,
   parameter int unsigned IW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [IW-1:0] cap_eff_i,
   input  logic          syn_zero_i,
   output logic          v2c_en_o,
   output logic          c2v_en_o,
   output logic          first_pass_o,
   output logic          busy_o,
   output logic          stop_o,
   output logic [IW-1:0] iters_done_o
);
   import ldpc_ctl_pkg::*;

   ctl_state_t    st_q;
   logic [IW-1:0] iter_q;
   logic          ph_last;

   if (PHASE_LEN == 1) begin : g_single
      assign ph_last = 1'b1;
   end else begin : g_count
      localparam int unsigned CW = $clog2(PHASE_LEN);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                           cnt_q <= '0;
         else if (st_q == ST_IDLE || ph_last)  cnt_q <= '0;
         else                                  cnt_q <= cnt_q + 1'b1;
      end
      assign ph_last = (cnt_q == CW'(PHASE_LEN - 1));
   end

   assign iters_done_o = iter_q + 1'b1;
   assign stop_o = (st_q == ST_C2V) && ph_last &&
                   (syn_zero_i || (iters_done_o >= cap_eff_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         iter_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q   <= ST_V2C;
               iter_q <= '0;
            end
            ST_V2C: if (ph_last) st_q <= ST_C2V;
            ST_C2V: if (ph_last) begin
               if (stop_o) st_q <= ST_IDLE;
               else begin
                  st_q   <= ST_V2C;
                  iter_q <= iters_done_o;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign v2c_en_o     = (st_q == ST_V2C);
   assign c2v_en_o     = (st_q == ST_C2V);
   assign first_pass_o = (st_q == ST_V2C) && (iter_q == '0);
   assign busy_o       = (st_q != ST_IDLE);

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl #(
   parameter int unsigned Z         = 5,
   parameter int unsigned NB        = 4,
   parameter int unsigned NC        = 3,
   parameter int unsigned PHASE_LEN = 2,
   parameter int unsigned IW        = 8,
   parameter int unsigned RESET_CAP = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               max_iter_wr_i,
   input  logic [IW-1:0]      max_iter_i,
   input  logic [NB*Z-1:0]    hd_i,
   output logic               v2c_en_o,
   output logic               c2v_en_o,
   output logic               first_pass_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               converged_o,
   output logic [NB*Z-1:0]    word_o,
   output logic [IW-1:0]      iters_o
);
   localparam int unsigned N = NB * Z;

   if (Z < 2)                 begin : g_bad_z   $error("Z must be at least 2");        end
   if (NB < 2)                begin : g_bad_nb  $error("NB must be at least 2");       end
   if (NC < 1 || NC > Z)      begin : g_bad_nc  $error("NC must be in 1..Z");          end
   if (PHASE_LEN < 1)         begin : g_bad_ph  $error("PHASE_LEN must be positive");  end
   if (RESET_CAP >= (1 << IW)) begin : g_bad_cap $error("RESET_CAP exceeds IW bits");  end

   logic          syn_zero;
   logic          stop;
   logic [IW-1:0] cap_eff;
   logic [IW-1:0] iters_done;

   ldpc_syndrome #(.Z(Z), .NB(NB), .NC(NC)) u_syn (
      .hd_i   (hd_i),
      .zero_o (syn_zero)
   );

   ldpc_iter_cap #(.IW(IW), .RESET_CAP(RESET_CAP)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (max_iter_wr_i),
      .val_i     (max_iter_i),
      .cap_eff_o (cap_eff)
   );

   ldpc_phase_seq #(.PHASE_LEN(PHASE_LEN), .IW(IW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .cap_eff_i    (cap_eff),
      .syn_zero_i   (syn_zero),
      .v2c_en_o     (v2c_en_o),
      .c2v_en_o     (c2v_en_o),
      .first_pass_o (first_pass_o),
      .busy_o       (busy_o),
      .stop_o       (stop),
      .iters_done_o (iters_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         converged_o <= 1'b0;
         word_o      <= '0;
         iters_o     <= '0;
      end else begin
         done_o <= stop;
         if (stop) begin
            converged_o <= syn_zero;
            word_o      <= hd_i;
            iters_o     <= iters_done;
         end
      end
   end

   logic [N-1:0] unused_n;
   assign unused_n = '0;

endmodule

// File: rtl/ldpc_iter_ctrl_chk.sv
module ldpc_iter_ctrl_chk #(
   parameter int unsigned N  = 20,
   parameter int unsigned IW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          max_iter_wr_i,
   input logic          v2c_en_o,
   input logic          c2v_en_o,
   input logic          first_pass_o,
   input logic          busy_o,
   input logic          done_o,
   input logic          converged_o,
   input logic [N-1:0]  word_o,
   input logic [IW-1:0] iters_o,
   input logic [IW-1:0] cap_eff
);
   p_excl_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(v2c_en_o && c2v_en_o));

   p_start_v2c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (v2c_en_o && first_pass_o));

   p_first_in_v2c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      first_pass_o |-> v2c_en_o);

   p_idle_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !v2c_en_o && !c2v_en_o));

   p_cap_noconv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !converged_o && !$past(max_iter_wr_i)) |-> (iters_o == cap_eff));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> (done_o || ($stable(word_o) && $stable(converged_o) && $stable(iters_o))));

   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind ldpc_iter_ctrl ldpc_iter_ctrl_chk #(.N(NB*Z), .IW(IW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .max_iter_wr_i (max_iter_wr_i),
   .v2c_en_o      (v2c_en_o),
   .c2v_en_o      (c2v_en_o),
   .first_pass_o  (first_pass_o),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .converged_o   (converged_o),
   .word_o        (word_o),
   .iters_o       (iters_o),
   .cap_eff       (cap_eff)
);

// File: tb/test_ldpc_iter_ctrl.sv
`timescale 1ns/1ps
module test_ldpc_iter_ctrl;
   localparam int Z = 5, NB = 4, NC = 3, P = 2, IW = 8;
   localparam int N = NB * Z, M = NC * Z;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          max_iter_wr_i = 1'b0;
   logic [IW-1:0] max_iter_i = '0;
   logic [N-1:0]  hd_i = '0;
   logic          v2c_en_o, c2v_en_o, first_pass_o, busy_o, done_o, converged_o;
   logic [N-1:0]  word_o;
   logic [IW-1:0] iters_o;

   always #2 clk = ~clk;

   ldpc_iter_ctrl #(.Z(Z), .NB(NB), .NC(NC), .PHASE_LEN(P), .IW(IW), .RESET_CAP(10)) i_ldpc_iter_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_iter_wr_i(max_iter_wr_i),
      .max_iter_i(max_iter_i), .hd_i(hd_i), .v2c_en_o(v2c_en_o), .c2v_en_o(c2v_en_o),
      .first_pass_o(first_pass_o), .busy_o(busy_o), .done_o(done_o),
      .converged_o(converged_o), .word_o(word_o), .iters_o(iters_o));

   int checks = 0, errors = 0, cycles = 0, n_done = 0;
   bit finished = 0;

   // behavioural reference: phase 0 idle, 1 bit-to-check, 2 check-to-bit
   int m_ph = 0, m_cnt = 0, m_iter = 0, m_cap = 10, m_iters = 0;
   logic m_done = 0, m_conv = 0;
   logic [N-1:0] m_word = '0;
   logic [N-1:0] hd_q[$];

   function automatic bit syn_ok(input logic [N-1:0] w);
      for (int c = 0; c < M; c++) begin
         bit par = 0;
         for (int k = 0; k < NB; k++) par ^= w[k*Z + ((c % Z) + (c / Z) * k) % Z];
         if (par) return 0;
      end
      return 1;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act %0h exp %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= 0; m_cnt <= 0; m_iter <= 0; m_cap <= 10; m_done <= 0;
         m_conv <= 0; m_word <= '0; m_iters <= 0;
      end else begin
         m_done <= 0;
         if (max_iter_wr_i) m_cap <= int'(max_iter_i);
         if (m_ph == 0) begin
            if (start_i) begin m_ph <= 1; m_cnt <= 0; m_iter <= 0; end
         end else if (m_cnt < P - 1) begin
            m_cnt <= m_cnt + 1;
         end else if (m_ph == 1) begin
            m_ph <= 2; m_cnt <= 0;
         end else begin
            if (syn_ok(hd_i) || (m_iter + 1 >= ((m_cap == 0) ? 1 : m_cap))) begin
               m_done <= 1; m_conv <= syn_ok(hd_i); m_word <= hd_i;
               m_iters <= m_iter + 1; m_ph <= 0;
            end else begin
               m_iter <= m_iter + 1; m_ph <= 1; m_cnt <= 0;
            end
         end
      end
   end

   // per-iteration hard decisions, keyed by the model's iteration count
   always @(negedge clk)
      hd_i = (hd_q.size() == 0) ? '0 : hd_q[(m_iter < hd_q.size()) ? m_iter : hd_q.size() - 1];

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(v2c_en_o == (m_ph == 1), "R2 v2c_en", v2c_en_o, m_ph == 1);
         chk(c2v_en_o == (m_ph == 2), "R2 c2v_en", c2v_en_o, m_ph == 2);
         chk(first_pass_o == (m_ph == 1 && m_iter == 0), "R3 first_pass", first_pass_o, m_ph == 1 && m_iter == 0);
         chk(busy_o == (m_ph != 0), "R8 busy", busy_o, m_ph != 0);
         chk(done_o == m_done, "R7 done", done_o, m_done);
         chk(converged_o == m_conv, "R5 converged", converged_o, m_conv);
         chk(word_o == m_word, "R7 word", word_o, m_word);
         chk(int'(iters_o) == m_iters, "R6 iters", iters_o, m_iters);
         if (done_o) n_done++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog act %0d exp %0d", cycles, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic set_cap(input int v);
      @(negedge clk); max_iter_wr_i = 1; max_iter_i = IW'(v);
      @(negedge clk); max_iter_wr_i = 0;
   endtask

   task automatic run(input int e_it, input bit e_cv, input logic [N-1:0] e_w, input string tag);
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
      while (!done_o) @(negedge clk);
      chk(int'(iters_o) == e_it, {tag, " iters"}, iters_o, e_it);
      chk(converged_o == e_cv, {tag, " converged"}, converged_o, e_cv);
      chk(word_o == e_w, {tag, " word"}, word_o, e_w);
      @(negedge clk);
   endtask

   initial begin
      logic [N-1:0] ones, cw2, w;
      ones = '1;
      cw2  = N'(5'h1f) | (N'(5'h1f) << (2*Z));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o && !v2c_en_o && !c2v_en_o && !first_pass_o, "R1 ctrl idle", busy_o, 0);
      chk(!converged_o && word_o == '0 && iters_o == '0, "R1 outputs zero", word_o, 0);

      // R5: codeword on first iteration
      hd_q = '{N'(0)};
      run(1, 1, '0, "R5 zero word");
      // R5/R2: converge on third iteration
      hd_q = '{N'(1) << 3, (N'(1) << 7) | N'(1), ones};
      run(3, 1, ones, "R5 late converge");
      // R4: two full bit blocks form a codeword
      hd_q = '{cw2};
      run(1, 1, cw2, "R4 block pair");
      // R6/R1: reset cap of 10 exhausted
      hd_q = '{N'(5'h1f)};
      run(10, 0, N'(5'h1f), "R6 reset cap");
      // R4: every single-bit word fails some row (cap 1)
      set_cap(1);
      for (int b = 0; b < N; b++) begin
         hd_q = '{N'(1) << b};
         run(1, 0, N'(1) << b, "R4 single bit");
      end
      // R9: written cap of 3, then zero acting as 1
      set_cap(3);
      hd_q = '{N'(1) << 11};
      run(3, 0, N'(1) << 11, "R9 cap three");
      set_cap(0);
      run(1, 0, N'(1) << 11, "R9 cap zero");
      // R8: start pulses while busy are ignored
      set_cap(6);
      hd_q = '{N'(3)};
      n_done = 0;
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
      repeat (5) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
      repeat (6) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
      while (!done_o) @(negedge clk);
      chk(int'(iters_o) == 6, "R8 iters unaffected", iters_o, 6);
      repeat (4) @(negedge clk);
      chk(n_done == 1, "R8 single done", n_done, 1);
      // R7: results hold while idle
      chk(word_o == N'(3) && !converged_o && !done_o, "R7 hold", word_o, 3);
      // R4/R5: random words, cap 2
      set_cap(2);
      for (int t = 0; t < 24; t++) begin
         w = N'($urandom);
         if (t % 4 == 0) w = w ^ w ^ ((t % 8 == 0) ? ones : cw2);
         hd_q = '{w};
         run(syn_ok(w) ? 1 : 2, syn_ok(w), w, "R4 random");
      end
      repeat (3) @(negedge clk);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule